// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block lets host software run single management transactions to an external Ethernet PHY over the two-wire MDIO bus. Software writes one 32-bit command word holding the PHY address, register address, write data, an opcode and a start flag. If the command is legal, the block raises a busy flag and serialises a Clause-22 frame on the bus. MDC is derived from the system clock, and the block drives MDIO through a separate output and output-enable pair. When the frame finishes, the block clears busy and, for a read, places the 16 bits sampled from the PHY in the low half of the same command word.

A separate mode register holds a Clause-45 enable bit. Only Clause-22 framing is built here, so starts are refused while that bit is set. The block ignores writes to either register while a frame is on the wire. This keeps the frame contents stable for its whole duration.

Top module: `mdio_c22_master`

## Requirements
- R1: After synchronous active-low reset, the command readback is 0, the Clause-45 enable reads 0, MDC is low and the MDIO driver is released (output enable 0).
- R2: A command write (wr_sel=0) while idle stores opcode in bits 27:26, PHY address in 25:21, register address in 20:16 and data in 15:0. If bit 29 is set and the opcode is 1 (write) or 2 (read), bit 29 reads back 1 from the next cycle on. If bit 29 is clear, the fields are stored and no frame starts.
- R3: A start with opcode 0 or 3, or with the Clause-45 enable set (mode register bit 0, written with wr_sel=1), is refused: bit 29 stays 0 and MDC stays low.
- R4: While bit 29 reads 1, writes to the command or mode register have no effect.
- R5: While busy, MDC is a clock with DIV_HALF system cycles low followed by DIV_HALF system cycles high for each bit. MDC is low when idle.
- R6: A write frame is 64 bits, sent MSB first and driven throughout: 32 ones, 0, 1, the two opcode bits, 5 PHY address bits, 5 register address bits, turnaround 1 then 0, then the 16 data bits.
- R7: In a read frame the first 46 bits (through the register address) are driven as in R6. The driver is released from the first turnaround bit through the last data bit.
- R8: In a read, MDIO is sampled at the rising MDC edge of each of the 16 data bits, MSB first. At completion the result replaces bits 15:0 of the command word, and the other fields are unchanged.
- R9: The MDIO output value and output enable change only while MDC is low.
- R10: Busy stays set for exactly 128*DIV_HALF system cycles after the accepting clock edge. It then clears, with MDC low and the driver released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command word, 1 the mode register |
| wr_data | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command word readback; bit 29 is busy |
| clause45_en | output | 1 | Mode register Clause-45 enable readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = driving) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench checks the whole frame, bit by bit, against a model driven by an elapsed-cycle count. An off-by-one in the bit counter would show up as a shifted address field or a wrong turnaround. Releasing the driver one bit late in a read would show up as the output enable still high during the first turnaround bit. It also checks that the completion edge falls exactly 128*DIV_HALF cycles after acceptance.

A PHY model places distinct patterns, including all-zero data under an all-ones command data field, on MDIO only during data bits. A capture at the wrong edge, or a captured result that is never written back, leaves a visibly wrong low half-word.

Other tests fire writes during a frame, starts with opcodes 0 and 3, and starts with Clause-45 mode set. A design that let any of these through would corrupt the frame in flight or start a frame that should have been refused.

// File: rtl/mdio_pkg.sv
// mdio_pkg: shared constants and types for the Clause-22 management master.
// Assumes a fixed 64-bit frame (32-bit preamble) with no preamble suppression.
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = 46;   // first turnaround bit position
    localparam int DATA_IDX   = 48;   // first data bit position
    localparam int START_BIT  = 29;   // start/busy flag in the command word
    localparam int MODE_C45   = 0;    // Clause-45 enable in the mode register
    localparam int WORD_W     = 32;
    localparam int DATA_W     = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_C45RD = 2'd3
    } mdio_op_e;

    // Bits 27:0 of the command word
    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_clk_gen.sv
// mdio_clk_gen: divides the system clock into MDC while run is high.
// Each bit cell is DIV_HALF cycles low then DIV_HALF cycles high.
// Assumes DIV_HALF >= 1. It flags the rising edge and the end of each cell.
module mdio_clk_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic cell_end
);
    localparam int CW = $clog2(DIV_HALF + 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          cnt_last;

    // Phase boundary: the last cycle of a half period
    assign cnt_last = (cnt_q == CW'(DIV_HALF - 1));
    assign rise_evt = run && cnt_last && !mdc_q;
    assign cell_end = run && cnt_last && mdc_q;
    assign mdc      = mdc_q;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_last) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// mdio_frame_seq: walks the 64 bit cells of one Clause-22 frame.
// It drives MDIO from the held command, releases the line for the read
// turnaround and data, and shifts in read data at MDC rising edges.
// Assumes cmd is stable while busy. The bit index advances as MDC falls.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  mdio_cmd_t         cmd,
    input  logic              rise_evt,
    input  logic              cell_end,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_word
);
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] frame;
    logic                  is_rd;
    logic                  released;

    // Whole frame image, MSB sent first
    assign frame = {{32{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad, 2'b10, cmd.data};
    assign is_rd = (cmd.op == OP_READ);

    // Line ownership and output bit for the current cell
    always_comb begin
        released = is_rd && (int'(idx_q) >= TA_IDX);
        mdio_oe  = busy && !released;
        mdio_o   = mdio_oe && frame[FRAME_BITS - 1 - int'(idx_q)];
        done     = busy && cell_end && (int'(idx_q) == FRAME_BITS - 1);
    end

    // Bit cell index
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            idx_q <= '0;
        end else if (cell_end) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Read data capture at MDC rising edges of the data cells
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (busy && rise_evt && is_rd && int'(idx_q) >= DATA_IDX) begin
            rd_word <= {rd_word[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// mdio_regs: command word and mode register with self-clearing busy.
// Accepts writes only while idle, refuses illegal starts and writes the
// read result back into the data field on completion.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_word,
    output mdio_cmd_t         cmd,
    output logic              busy,
    output logic              c45_en
);
    mdio_cmd_t new_cmd;
    logic      legal_start;

    // Decode of an incoming command word
    always_comb begin
        new_cmd     = mdio_cmd_t'(wr_data[27:0]);
        legal_start = wr_data[START_BIT] && !c45_en &&
                      (new_cmd.op == OP_WRITE || new_cmd.op == OP_READ);
    end

    // Register state: completion first, then idle-only writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd    <= '0;
            busy   <= 1'b0;
            c45_en <= 1'b0;
        end else if (done) begin
            busy <= 1'b0;
            if (cmd.op == OP_READ) begin
                cmd.data <= rd_word;
            end
        end else if (wr_en && !busy) begin
            if (wr_sel) begin
                c45_en <= wr_data[MODE_C45];
            end else begin
                cmd  <= new_cmd;
                busy <= legal_start;
            end
        end
    end
endmodule

// File: rtl/mdio_c22_master.sv
// mdio_c22_master: top of the Clause-22 management master.
// Connects the register file, the MDC divider and the frame sequencer.
// Assumes the pad logic combines mdio_o/mdio_oe into a tri-state buffer.
module mdio_c22_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_rdata,
    output logic        clause45_en,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         cmd;
    logic              busy;
    logic              rise_evt;
    logic              cell_end;
    logic              done;
    logic [DATA_W-1:0] rd_word;

    mdio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .done    (done),
        .rd_word (rd_word),
        .cmd     (cmd),
        .busy    (busy),
        .c45_en  (clause45_en)
    );

    mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .cell_end (cell_end)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .cmd      (cmd),
        .rise_evt (rise_evt),
        .cell_end (cell_end),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_word  (rd_word)
    );

    // Readback: reserved bits read as zero, busy at bit 29
    assign cmd_rdata = {2'b00, busy, 1'b0, cmd};
endmodule

// File: rtl/mdio_c22_master_chk.sv
// mdio_c22_master_chk: port-level properties of the management master.
module mdio_c22_master_chk #(
    parameter int DIV_HALF = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_rdata,
    input logic        clause45_en,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic        busy;
    logic        idle_cmd;
    logic        legal_op;
    logic [31:0] hi_cnt;

    assign busy     = cmd_rdata[29];
    assign idle_cmd = wr_en && !wr_sel && !busy;
    assign legal_op = (wr_data[27:26] == 2'd1) || (wr_data[27:26] == 2'd2);

    // Count consecutive MDC high cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !mdc) hi_cnt <= '0;
        else                hi_cnt <= hi_cnt + 1'b1;
    end

    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && wr_data[29] && legal_op && !clause45_en) |=> busy);

    p_reject_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd && (!legal_op || clause45_en)) |=> !busy);

    p_hold_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_rdata[27:16]) && $stable(clause45_en)));

    p_mdc_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == DIV_HALF));

    p_mdc_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    p_change_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_c22_master mdio_c22_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cmd_rdata   (cmd_rdata),
    .clause45_en (clause45_en),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_c22_master_tb.sv
// Bench: behavioural per-cycle model, compared on every falling clock edge.
module mdio_c22_master_tb;
    localparam int D = 3;
    localparam int FRAME_CYC = 128 * D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rdata;
    logic        clause45_en;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    // Model state
    bit          m_busy = 0;
    bit          m_c45  = 0;
    logic [27:0] m_cmd  = '0;
    int          t      = 0;
    logic [15:0] phy_val = '0;
    bit          frame_q[$];
    bit          cmp_on = 0;
    logic        prev_o = 0, prev_oe = 0;

    always #5 clk = ~clk;

    mdio_c22_master #(.DIV_HALF(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_rdata(cmd_rdata), .clause45_en(clause45_en),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void build_frame(input logic [27:0] c);
        frame_q.delete();
        for (int i = 0; i < 32; i++) frame_q.push_back(1'b1);
        frame_q.push_back(1'b0);
        frame_q.push_back(1'b1);
        for (int i = 27; i >= 16; i--) frame_q.push_back(c[i]);
        frame_q.push_back(1'b1);
        frame_q.push_back(1'b0);
        for (int i = 15; i >= 0; i--) frame_q.push_back(c[i]);
    endfunction

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_c45 = 0; m_cmd = '0; t = 0;
        end else if (m_busy) begin
            t = t + 1;
            if (t == FRAME_CYC) begin
                m_busy = 0;
                if (m_cmd[27:26] == 2'd2) m_cmd[15:0] = phy_val;
            end
        end else if (wr_en) begin
            if (wr_sel) m_c45 = wr_data[0];
            else begin
                m_cmd = wr_data[27:0];
                if (wr_data[29] && !m_c45 &&
                    (wr_data[27:26] == 2'd1 || wr_data[27:26] == 2'd2)) begin
                    m_busy = 1; t = 0; build_frame(wr_data[27:0]);
                end
            end
        end
    end

    // Per-cycle comparison and PHY drive on falling edges
    always @(negedge clk) begin
        if (cmp_on) begin
            int  bitn;
            bit  rd, e_mdc, e_oe;
            logic [31:0] e_cmd;
            bitn  = t / (2 * D);
            rd    = (m_cmd[27:26] == 2'd2);
            e_mdc = m_busy && ((t % (2 * D)) >= D);
            e_oe  = m_busy && !(rd && bitn >= 46);
            e_cmd = {2'b00, m_busy, 1'b0, m_cmd};
            check(mdc === e_mdc, "R5 mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check(mdio_oe === e_oe, rd ? "R7 oe" : "R6 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            if (e_oe)
                check(mdio_o === frame_q[bitn], "R6 mdio_o bit", {31'd0, mdio_o},
                      {31'd0, frame_q[bitn]});
            check(cmd_rdata === e_cmd, "R10 R8 R4 cmd_rdata", cmd_rdata, e_cmd);
            check(clause45_en === m_c45, "R4 mode", {31'd0, clause45_en}, {31'd0, m_c45});
            if ((mdio_o !== prev_o || mdio_oe !== prev_oe) && mdc)
                check(1'b0, "R9 change while mdc high", {31'd0, mdio_o}, {31'd0, prev_o});
            prev_o  = mdio_o;
            prev_oe = mdio_oe;
            mdio_i = (m_busy && rd && bitn >= 48) ? phy_val[63 - bitn] : 1'b1;
        end
    end

    task automatic reg_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit st, input logic [1:0] op,
                                       input logic [4:0] ph, input logic [4:0] rg,
                                       input logic [15:0] dt);
        return {2'b00, st, 1'b0, op, ph, rg, dt};
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_rdata === 32'd0, "R1 cmd reset", cmd_rdata, 32'd0);
        check(clause45_en === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle pins",
              {29'd0, clause45_en, mdc, mdio_oe}, 32'd0);
        prev_o = mdio_o; prev_oe = mdio_oe;
        cmp_on = 1;

        // R2 store without start
        reg_write(0, mk(0, 2'd1, 5'h0A, 5'h15, 16'h1234));
        check(cmd_rdata === mk(0, 2'd1, 5'h0A, 5'h15, 16'h1234), "R2 store no start",
              cmd_rdata, mk(0, 2'd1, 5'h0A, 5'h15, 16'h1234));

        // R6 write frame, R4 writes while busy
        reg_write(0, mk(1, 2'd1, 5'h11, 5'h04, 16'hA5C3));
        check(cmd_rdata[29] === 1'b1, "R2 busy set", cmd_rdata, mk(1, 2'd1, 5'h11, 5'h04, 16'hA5C3));
        repeat (40) @(negedge clk);
        reg_write(0, mk(1, 2'd2, 5'h03, 5'h02, 16'h0F0F));
        reg_write(1, 32'd1);
        check(cmd_rdata === mk(1, 2'd1, 5'h11, 5'h04, 16'hA5C3) && clause45_en === 1'b0,
              "R4 ignored while busy", cmd_rdata, mk(1, 2'd1, 5'h11, 5'h04, 16'hA5C3));
        wait_idle();
        check(cmd_rdata === mk(0, 2'd1, 5'h11, 5'h04, 16'hA5C3), "R10 write done",
              cmd_rdata, mk(0, 2'd1, 5'h11, 5'h04, 16'hA5C3));

        // R7 R8 read frames
        phy_val = 16'h3C5A;
        reg_write(0, mk(1, 2'd2, 5'h1F, 5'h00, 16'h0000));
        wait_idle();
        check(cmd_rdata === mk(0, 2'd2, 5'h1F, 5'h00, 16'h3C5A), "R8 read data",
              cmd_rdata, mk(0, 2'd2, 5'h1F, 5'h00, 16'h3C5A));
        phy_val = 16'h0000;
        reg_write(0, mk(1, 2'd2, 5'h01, 5'h1E, 16'hFFFF));
        wait_idle();
        check(cmd_rdata === mk(0, 2'd2, 5'h01, 5'h1E, 16'h0000), "R8 read zeros",
              cmd_rdata, mk(0, 2'd2, 5'h01, 5'h1E, 16'h0000));

        // R3 refused starts
        reg_write(0, mk(1, 2'd3, 5'h02, 5'h02, 16'h5555));
        check(cmd_rdata[29] === 1'b0 && mdc === 1'b0, "R3 opcode 3 refused",
              cmd_rdata, mk(0, 2'd3, 5'h02, 5'h02, 16'h5555));
        reg_write(0, mk(1, 2'd0, 5'h02, 5'h02, 16'h5555));
        check(cmd_rdata[29] === 1'b0, "R3 opcode 0 refused", cmd_rdata,
              mk(0, 2'd0, 5'h02, 5'h02, 16'h5555));
        reg_write(1, 32'd1);
        check(clause45_en === 1'b1, "R3 mode set", {31'd0, clause45_en}, 32'd1);
        reg_write(0, mk(1, 2'd2, 5'h02, 5'h02, 16'h5555));
        repeat (4) @(negedge clk);
        check(cmd_rdata[29] === 1'b0 && mdc === 1'b0, "R3 clause45 refused",
              cmd_rdata, mk(0, 2'd2, 5'h02, 5'h02, 16'h5555));
        reg_write(1, 32'd0);

        // R6 second write pattern after mode cleared
        reg_write(0, mk(1, 2'd1, 5'h00, 5'h1F, 16'h8001));
        wait_idle();
        check(cmd_rdata === mk(0, 2'd1, 5'h00, 5'h1F, 16'h8001) && mdio_oe === 1'b0,
              "R10 final idle", cmd_rdata, mk(0, 2'd1, 5'h00, 5'h1F, 16'h8001));

        cmp_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule